// File: doc/BRIEF.md
# ADC Control/Status Register with Conversion Sequencer

This block is the byte-wide control and status register of one analog-to-digital conversion unit, together with the sequencer that issues conversion requests to an external converter. Software selects a mode, a channel and an interrupt enable by writing the register. It then pulses `start`. The sequencer holds `convReq` high with a channel number on `convCh`. The converter answers each finished conversion with a one-cycle `convDone` pulse.

In single mode, one conversion of the selected channel runs and the completion flag is set. In scan mode, channels 0 up to the channel field are converted in ascending order, and the flag is set only when the last channel of the group is done. A one-pass scan then goes idle. A continuous scan, selected by the `contScan` input, restarts at channel 0 with no gap. The flag is cleared by a DMA acknowledge, or by a write of zero that follows a read which saw the flag set. Software can never set the flag.

Top module: `adc_ctl_seq`

## Requirements
- R1: After reset, `rdData` reads 0x08, and `irq` and `convReq` are low.
- R2: Bit 3 always reads 1 and ignores writes. Bit 6 (interrupt enable), bits 5:4 (mode) and bits 2:0 (channel) take the written value on any write.
- R3: Writing 1 to bit 7 (completion flag) never sets it and never changes it.
- R4: A write with bit 7 = 0 clears the flag only when a read with `rdEn` high has observed the flag at 1 since it was last set. Without such a read, the flag stays set.
- R5: A `dmaAck` pulse clears the flag.
- R6: In single mode (mode 00), a `start` pulse while idle raises `convReq` on the next cycle with `convCh` equal to the channel field. The `convDone` pulse sets the flag and drops `convReq` on the same edge.
- R7: In one-pass scan (mode 01, `contScan` = 0), `convCh` steps 0, 1, … up to the channel field, one step per `convDone`. The flag stays clear until the last conversion, then sets, and `convReq` drops.
- R8: In continuous scan (mode 01, `contScan` = 1), the flag sets at the end of each pass, and `convReq` stays high with `convCh` back at 0 on the next cycle.
- R9: Mode codes 10 and 11 behave as single mode, and `contScan` has no effect outside scan mode.
- R10: `irq` is high exactly when the flag and the interrupt enable are both 1.
- R11: When a conversion completion that sets the flag coincides with a clearing write or a `dmaAck`, the flag ends up set.
- R12: A `start` pulse while a conversion sequence is running is ignored: the channel in progress does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (arms the flag clear) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Register contents |
| start | input | 1 | Start a conversion sequence (ignored while busy) |
| contScan | input | 1 | 1 = continuous scan, 0 = one pass; used only in scan mode |
| convReq | output | 1 | Conversion request to the converter |
| convCh | output | 3 | Channel being converted |
| convDone | input | 1 | One-cycle completion pulse from the converter |
| dmaAck | input | 1 | DMA acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted channel counter shows at once on `convCh` during a scan: the bench checks the channel on every conversion it serves. A wrong busy state shows one cycle after the completing edge, as `convReq` staying high or dropping. A lost or stray flag update shows on `rdData[7]` and `irq` on the cycle right after the edge that should have changed it. A wrongly held read arm shows only at the next zero-write, as a flag that clears when it should not, or the other way round.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int REG_W  = 8;
  localparam int CH_W   = 3;
  localparam int FLAG_B = 7;
  localparam int IE_B   = 6;
  localparam int MODE_HI = 5;
  localparam int MODE_LO = 4;
  localparam int RSVD_B = 3;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SCAN   = 2'b01,
    MODE_ALT2   = 2'b10,
    MODE_ALT3   = 2'b11
  } convMode_e;

  typedef struct packed {
    logic setFlag;
    logic busy;
  } ctlStrobe_t;
endpackage

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_ctl_pkg::*;
#(
  parameter int CHW = CH_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            contScan,
  input  logic            convDone,
  input  convMode_e       mode,
  input  logic [CHW-1:0]  chField,
  output logic [CHW-1:0]  curCh,
  output ctlStrobe_t      strobe
);
  logic busy;
  logic isScan;
  logic lastInGroup;

  assign isScan      = (mode == MODE_SCAN);
  assign lastInGroup = (curCh >= chField);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      curCh <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        curCh <= isScan ? '0 : chField;
      end
    end else if (convDone) begin
      if (!isScan) begin
        busy <= 1'b0;
      end else if (lastInGroup) begin
        if (contScan) curCh <= '0;
        else          busy  <= 1'b0;
      end else begin
        curCh <= curCh + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.busy    = busy;
    strobe.setFlag = busy && convDone && (!isScan || lastInGroup);
  end
endmodule

// File: rtl/adc_reg_dp.sv
module adc_reg_dp
  import adc_ctl_pkg::*;
#(
  parameter int CHW = CH_W,
  parameter int RW  = REG_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic [RW-1:0]   wrData,
  input  logic            dmaAck,
  input  ctlStrobe_t      strobe,
  output logic [RW-1:0]   rdData,
  output convMode_e       mode,
  output logic [CHW-1:0]  chField,
  output logic            irq
);
  logic flag;
  logic intEn;
  logic armed;
  logic swClear;
  logic anyClear;

  assign swClear  = wrEn && !wrData[FLAG_B] && armed;
  assign anyClear = swClear || dmaAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag    <= 1'b0;
      intEn   <= 1'b0;
      mode    <= MODE_SINGLE;
      chField <= '0;
      armed   <= 1'b0;
    end else begin
      if (strobe.setFlag)  flag <= 1'b1;
      else if (anyClear)   flag <= 1'b0;

      if (anyClear)            armed <= 1'b0;
      else if (rdEn && flag)   armed <= 1'b1;

      if (wrEn) begin
        intEn   <= wrData[IE_B];
        mode    <= convMode_e'(wrData[MODE_HI:MODE_LO]);
        chField <= wrData[CHW-1:0];
      end
    end
  end

  assign rdData = {flag, intEn, mode, 1'b1, chField};
  assign irq    = flag && intEn;
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        start,
  input  logic        contScan,
  output logic        convReq,
  output logic [2:0]  convCh,
  input  logic        convDone,
  input  logic        dmaAck,
  output logic        irq
);
  ctlStrobe_t        strobe;
  convMode_e         mode;
  logic [CH_W-1:0]   chField;

  adc_seq_ctl #(.CHW(CH_W)) u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .contScan(contScan),
    .convDone(convDone), .mode(mode), .chField(chField),
    .curCh(convCh), .strobe(strobe)
  );

  adc_reg_dp #(.CHW(CH_W), .RW(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .dmaAck(dmaAck), .strobe(strobe), .rdData(rdData), .mode(mode),
    .chField(chField), .irq(irq)
  );

  assign convReq = strobe.busy;
endmodule

// File: rtl/adc_ctl_seq_chk.sv
module adc_ctl_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       convReq,
  input logic       convDone,
  input logic       dmaAck,
  input logic       irq
);
  assert_rsvd_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[3]);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq == (rdData[7] && rdData[6]));

  // Flag can only rise from a completion the converter reported (R3, R6)
  assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[7]) |-> $past(convDone && convReq));

  assert_flag_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdData[7]) |-> $past(dmaAck || (wrEn && !wrData[7])));

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convDone && rdData[5:4] != 2'b01) |=> rdData[7]);

  assert_single_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convDone && rdData[5:4] != 2'b01) |=> !convReq);
endmodule

bind adc_ctl_seq adc_ctl_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .convReq(convReq), .convDone(convDone), .dmaAck(dmaAck), .irq(irq)
);

// File: tb/tb_adc_ctl_seq.sv
module tb_adc_ctl_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, rdEn = 0, start = 0, contScan = 0, convDone = 0, dmaAck = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic convReq, irq;
  logic [2:0] convCh;

  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ctl_seq dut (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] regVal(logic f, logic ie, logic [1:0] m, logic [2:0] c);
    return {f, ie, m, 1'b1, c};
  endfunction

  // all tasks start and end at a negedge
  task automatic doWrite(input logic [7:0] v);
    wrEn = 1; wrData = v; @(negedge clk); wrEn = 0;
  endtask
  task automatic doRead();
    rdEn = 1; @(negedge clk); rdEn = 0;
  endtask
  task automatic pulseStart();
    start = 1; @(negedge clk); start = 0;
  endtask
  task automatic serve(input logic [2:0] expCh, input string tag);
    chk(convReq === 1'b1, tag, convReq, 1);
    chk(convCh === expCh, tag, convCh, expCh);
    convDone = 1; @(negedge clk); convDone = 0;
  endtask
  task automatic clearFlag(input logic [7:0] keep);
    doRead(); doWrite(keep & 8'h7F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk(rdData === 8'h08, "R1 reset reg", rdData, 8'h08);
    chk(irq === 1'b0, "R1 reset irq", irq, 0);
    chk(convReq === 1'b0, "R1 reset req", convReq, 0);

    // R2 field writes, reserved bit
    doWrite(8'h00); chk(rdData === 8'h08, "R2 write zero", rdData, 8'h08);
    doWrite(8'h77); chk(rdData === 8'h7F, "R2 write all", rdData, 8'h7F);
    // R3 write 1 to flag while clear
    doWrite(8'hF5); chk(rdData === 8'h7D, "R3 flag not set by sw", rdData, 8'h7D);
    chk(irq === 1'b0, "R10 irq flag0", irq, 0);

    // R6 / R9 single-mode sweep over modes 00,10,11 and all channels
    for (int m = 0; m < 4; m++) begin
      if (m == 1) continue;
      for (int c = 0; c < 8; c++) begin
        contScan = c[0];
        v = regVal(0, 0, m[1:0], c[2:0]);
        doWrite(v);
        chk(convReq === 1'b0, "R6 idle before start", convReq, 0);
        pulseStart();
        serve(c[2:0], (m == 0) ? "R6 single channel" : "R9 alt mode channel");
        chk(rdData === regVal(1, 0, m[1:0], c[2:0]), "R6 flag after single", rdData, regVal(1, 0, m[1:0], c[2:0]));
        chk(convReq === 1'b0, "R9 single stops", convReq, 0);
        clearFlag(v);
        chk(rdData[7] === 1'b0, "R4 cleared after read", rdData[7], 0);
      end
    end
    contScan = 0;

    // R7 one-pass scan sweep
    for (int c = 0; c < 8; c++) begin
      v = regVal(0, 0, 2'b01, c[2:0]);
      doWrite(v);
      pulseStart();
      for (int i = 0; i <= c; i++) begin
        chk(rdData[7] === 1'b0, "R7 flag clear mid scan", rdData[7], 0);
        serve(i[2:0], "R7 scan order");
      end
      chk(rdData[7] === 1'b1, "R7 flag at end", rdData[7], 1);
      chk(convReq === 1'b0, "R7 idle after pass", convReq, 0);
      clearFlag(v);
    end

    // R8 continuous scan
    contScan = 1;
    v = regVal(0, 0, 2'b01, 3'd2);
    doWrite(v);
    pulseStart();
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 3; i++) serve(i[2:0], "R8 continuous order");
      chk(rdData[7] === 1'b1, "R8 flag per pass", rdData[7], 1);
      chk(convReq === 1'b1 && convCh === 3'd0, "R8 restart at 0", {convReq, convCh}, 4'h8);
      doRead(); doWrite(v);
    end
    contScan = 0;
    for (int i = 0; i < 3; i++) serve(i[2:0], "R8 final pass");
    chk(convReq === 1'b0, "R8 stop after one-pass", convReq, 0);

    // R4 zero-write without read does not clear; R3 write 1 keeps flag
    chk(rdData[7] === 1'b1, "R4 flag set", rdData[7], 1);
    doWrite(v & 8'h7F);
    chk(rdData[7] === 1'b1, "R4 no read no clear", rdData[7], 1);
    doRead(); doWrite(v | 8'h80);
    chk(rdData[7] === 1'b1, "R3 write one keeps flag", rdData[7], 1);
    doWrite(v & 8'h7F);
    chk(rdData[7] === 1'b0, "R4 armed write clears", rdData[7], 0);

    // R5 DMA clear, R10 irq
    v = regVal(0, 1, 2'b00, 3'd4);
    doWrite(v);
    chk(irq === 1'b0, "R10 irq ie only", irq, 0);
    pulseStart(); serve(3'd4, "R10 conv");
    chk(irq === 1'b1, "R10 irq set", irq, 1);
    doWrite(v & 8'h3F);
    chk(irq === 1'b0, "R10 irq masked", irq, 0);
    dmaAck = 1; @(negedge clk); dmaAck = 0;
    chk(rdData[7] === 1'b0, "R5 dma clears", rdData[7], 0);

    // R11 set wins over armed clear write and over dma
    v = regVal(0, 0, 2'b00, 3'd1);
    doWrite(v);
    pulseStart(); serve(3'd1, "R11 first");
    doRead();
    pulseStart();
    convDone = 1; wrEn = 1; wrData = v; @(negedge clk);
    convDone = 0; wrEn = 0;
    chk(rdData[7] === 1'b1, "R11 set beats write", rdData[7], 1);
    pulseStart();
    convDone = 1; dmaAck = 1; @(negedge clk);
    convDone = 0; dmaAck = 0;
    chk(rdData[7] === 1'b1, "R11 set beats dma", rdData[7], 1);
    dmaAck = 1; @(negedge clk); dmaAck = 0;

    // R12 start while busy ignored
    v = regVal(0, 0, 2'b01, 3'd3);
    doWrite(v);
    pulseStart();
    serve(3'd0, "R12 scan ch0");
    pulseStart();
    chk(convCh === 3'd1, "R12 restart ignored", convCh, 1);
    for (int i = 1; i < 4; i++) serve(i[2:0], "R12 rest");
    chk(convReq === 1'b0 && rdData[7] === 1'b1, "R12 pass done", {convReq, rdData[7]}, 1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule